// File: doc/BRIEF.md
# I2C SCL Period Generator with Stretch Detection

This block produces the serial clock of an I2C master as an open-drain drive enable. Each bus clock period has two counted phases. The low phase starts counting on the cycle the block itself pulls SCL down. That means the programmed low count has to cover both the required low time and the line's fall time. Once the low count expires, the block releases SCL. It then waits until a synchronized copy of the real SCL line reads high before it starts the high count. Rise time and any clock stretching by a slave therefore lengthen the period without shortening the measured high time. The high count is sized to include the SDA fall time as well, so it also meets the START hold time.

Both counts are 9 bits wide. The lower eight bits of each come from their own inputs. The two top bits arrive on a separate two-bit input, because in the surrounding register file they live in another register. Counts are measured in ticks of a count clock. The tick is either the block clock or the block clock divided by two. The bit engine gets a one-cycle strobe when SCL is pulled low and another when the high phase begins, and uses them to time data shifting and sampling. START/STOP generation and the data path belong to other blocks.

Top module: `scl_period_gen`

## Requirements
- R1: While reset is asserted, `sclOe`, `fallStrobe` and `riseStrobe` are 0. While `enable` is 0, they are 0 from the next clock on.
- R2: The low phase (`sclOe`=1) lasts exactly `Lc*D` clock cycles. `Lc` is the low count `{countExt[1], lowCountBase}` (with R6 applied) and `D` is the divide ratio from R5.
- R3: The high phase lasts exactly `Hc*D` clock cycles, counted from the cycle of `riseStrobe` up to the cycle before the next `fallStrobe`. `Hc` is the high count `{countExt[0], highCountBase}` (with R6 applied).
- R4: After SCL is released, the high phase starts only once the synchronized SCL input has been seen low and then high. With no stretching, `riseStrobe` comes SYNC_STAGES+1 cycles after the first released cycle. If the line is held low for S extra sampling edges, it comes S cycles later.
- R5: `divBy2`=0 gives one count tick per clock (D=1). `divBy2`=1 gives one tick every second clock (D=2). The divider restarts at the start of each phase.
- R6: A programmed count of 0 (in either phase) behaves as a count of 1, so SCL never stalls.
- R7: `fallStrobe` is a single-cycle pulse in the first cycle of each low phase, while `sclOe`=1. `riseStrobe` is a single-cycle pulse in the first cycle of each high phase, while `sclOe`=0.
- R8: Clearing `enable` releases SCL on the next clock and resets both counters and the divider. A later re-enable starts with a complete low phase.
- R9: Bit 1 of `countExt` is bit 8 of the low count and bit 0 is bit 8 of the high count, so counts from 256 to 511 are honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the clock generator; 0 releases SCL and clears state |
| divBy2 | input | 1 | Count clock select: 0 = every clock, 1 = every second clock |
| lowCountBase | input | 8 | Low-phase count bits 7:0 |
| highCountBase | input | 8 | High-phase count bits 7:0 |
| countExt | input | 2 | Bit 8 of the counts: [1] low, [0] high |
| sclIn | input | 1 | Sampled level of the SCL line |
| sclOe | output | 1 | Open-drain enable: 1 pulls SCL low |
| fallStrobe | output | 1 | One-cycle pulse at the start of each low phase |
| riseStrobe | output | 1 | One-cycle pulse at the start of each high phase |

## Verification
The assertions check on every cycle that each strobe matches the drive state it marks and that a fall strobe never repeats on back-to-back cycles. They also check that a disable releases the line, that a rise strobe always follows a high synchronized input, that divided ticks are never adjacent, and that the low-seen flag stays set once set. Exact phase lengths, the zero-count substitution, the effect of the ninth bits and the delay added by a stretching slave depend on whole periods, so only the bench can show them. It does this by sweeping small low and high counts under both divide ratios, adding boundary counts above 255, holding SCL low for several stretch lengths, and disabling mid-phase.

// File: rtl/scl_period_pkg.sv
package scl_period_pkg;

  // Phase of the generated SCL period
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;     // zero counter, divider and low-seen flag
    logic run;       // a counted phase is active
    logic selHigh;   // compare against the high limit
    logic trackLow;  // watch the synchronized line for a low level
  } dpCtl_t;

endpackage

// File: rtl/scl_period_dp.sv
module scl_period_dp
  import scl_period_pkg::*;
#(
  parameter int BASE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              divBy2,
  input  logic [BASE_W-1:0] lowBase,
  input  logic [BASE_W-1:0] highBase,
  input  logic [1:0]        countExt,
  input  logic              sclIn,
  output logic              sclSync,
  output logic              lowSeen,
  output logic              phaseDone
);

  localparam int CNT_W = BASE_W + 1;

  // Input synchronizer; resets to the released (high) level
  logic [SYNC_STAGES-1:0] syncQ;
  logic [SYNC_STAGES-1:0] syncNext;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_single
      assign syncNext = sclIn;
    end else begin : g_sync_chain
      assign syncNext = {syncQ[SYNC_STAGES-2:0], sclIn};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= syncNext;
  end

  assign sclSync = syncQ[SYNC_STAGES-1];

  // Phase limits: 9-bit counts, zero behaves as one (R6, R9)
  logic [CNT_W-1:0] lowRaw, highRaw, lowLim, highLim, activeLim, termCount;

  assign lowRaw    = {countExt[1], lowBase};
  assign highRaw   = {countExt[0], highBase};
  assign lowLim    = (lowRaw  == '0) ? CNT_W'(1) : lowRaw;
  assign highLim   = (highRaw == '0) ? CNT_W'(1) : highRaw;
  assign activeLim = ctl.selHigh ? highLim : lowLim;
  assign termCount = activeLim - CNT_W'(1);

  // Count-clock prescaler, restarted at every phase start (R5)
  logic prePhase;
  logic tick;
  logic [CNT_W-1:0] cnt;

  assign tick = ctl.run && (!divBy2 || prePhase);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prePhase <= 1'b0;
      cnt      <= '0;
      lowSeen  <= 1'b0;
    end else if (ctl.clear) begin
      prePhase <= 1'b0;
      cnt      <= '0;
      lowSeen  <= 1'b0;
    end else begin
      if (ctl.run) prePhase <= ~prePhase;
      if (tick)    cnt      <= cnt + CNT_W'(1);
      if (ctl.trackLow && !sclSync) lowSeen <= 1'b1;
    end
  end

  // Greater-or-equal keeps the phase finite if a limit is lowered mid-phase
  assign phaseDone = tick && (cnt >= termCount);

  // R5: with the divider selected, two ticks are never adjacent
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (tick && divBy2) |=> !(tick && divBy2));

  // R4: once the low level is seen it stays seen until the next phase start
  a_r4_low_seen_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (lowSeen && !ctl.clear) |=> lowSeen);

endmodule

// File: rtl/scl_period_ctrl.sv
module scl_period_ctrl
  import scl_period_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   enable,
  input  logic   sclSync,
  input  logic   lowSeen,
  input  logic   phaseDone,
  output dpCtl_t ctl,
  output logic   sclOe,
  output logic   fallStrobe,
  output logic   riseStrobe
);

  phase_e ph, nextPh;

  always_comb begin
    nextPh = ph;
    unique case (ph)
      PH_IDLE: nextPh = PH_LOW;
      PH_LOW:  if (phaseDone) nextPh = PH_WAIT;
      PH_WAIT: if (sclSync && lowSeen) nextPh = PH_HIGH;
      PH_HIGH: if (phaseDone) nextPh = PH_LOW;
      default: nextPh = PH_IDLE;
    endcase
    if (!enable) nextPh = PH_IDLE;
  end

  logic enterLow, enterHigh;
  assign enterLow  = (nextPh == PH_LOW)  && (ph != PH_LOW);
  assign enterHigh = (nextPh == PH_HIGH) && (ph != PH_HIGH);

  always_comb begin
    ctl.clear    = enterLow || enterHigh || (nextPh == PH_IDLE) || (ph == PH_IDLE);
    ctl.run      = (ph == PH_LOW) || (ph == PH_HIGH);
    ctl.selHigh  = (ph == PH_HIGH);
    ctl.trackLow = (ph == PH_LOW) || (ph == PH_WAIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph         <= PH_IDLE;
      sclOe      <= 1'b0;
      fallStrobe <= 1'b0;
      riseStrobe <= 1'b0;
    end else begin
      ph         <= nextPh;
      sclOe      <= (nextPh == PH_LOW);
      fallStrobe <= enterLow;
      riseStrobe <= enterHigh;
    end
  end

  // R7: fall strobe marks a driven-low cycle, rise strobe a released one
  a_r7_fall_while_driven: assert property (@(posedge clk) disable iff (!rstN)
    fallStrobe |-> sclOe);

  a_r7_rise_while_released: assert property (@(posedge clk) disable iff (!rstN)
    riseStrobe |-> !sclOe);

  a_r7_fall_single: assert property (@(posedge clk) disable iff (!rstN)
    fallStrobe |=> !fallStrobe);

  // R1 / R8: a disabled block releases the line on the next clock
  a_r1_disable_releases: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclOe && !fallStrobe && !riseStrobe));

  // R4: the high phase only begins after the synchronized line read high
  a_r4_rise_after_high: assert property (@(posedge clk) disable iff (!rstN)
    riseStrobe |-> $past(sclSync));

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_period_pkg::*;
#(
  parameter int BASE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              divBy2,
  input  logic [BASE_W-1:0] lowCountBase,
  input  logic [BASE_W-1:0] highCountBase,
  input  logic [1:0]        countExt,
  input  logic              sclIn,
  output logic              sclOe,
  output logic              fallStrobe,
  output logic              riseStrobe
);

  dpCtl_t dpCtl;
  logic   sclSync, lowSeen, phaseDone;

  scl_period_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .sclSync    (sclSync),
    .lowSeen    (lowSeen),
    .phaseDone  (phaseDone),
    .ctl        (dpCtl),
    .sclOe      (sclOe),
    .fallStrobe (fallStrobe),
    .riseStrobe (riseStrobe)
  );

  scl_period_dp #(
    .BASE_W      (BASE_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (dpCtl),
    .divBy2    (divBy2),
    .lowBase   (lowCountBase),
    .highBase  (highCountBase),
    .countExt  (countExt),
    .sclIn     (sclIn),
    .sclSync   (sclSync),
    .lowSeen   (lowSeen),
    .phaseDone (phaseDone)
  );

endmodule

// File: tb/scl_period_gen_tb.sv
module scl_period_gen_tb;

  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic divBy2 = 1'b0;
  logic [7:0] lowCountBase = '0;
  logic [7:0] highCountBase = '0;
  logic [1:0] countExt = '0;
  logic holdLow = 1'b0;
  logic sclIn;
  logic sclOe, fallStrobe, riseStrobe;

  always #10 clk = ~clk;  // 50 MHz

  // Open-drain line: low if the block or a stretching slave pulls it
  assign sclIn = !(sclOe || holdLow);

  scl_period_gen #(.BASE_W(8), .SYNC_STAGES(SYNC)) u_dut (
    .clk           (clk),
    .rstN          (rstN),
    .enable        (enable),
    .divBy2        (divBy2),
    .lowCountBase  (lowCountBase),
    .highCountBase (highCountBase),
    .countExt      (countExt),
    .sclIn         (sclIn),
    .sclOe         (sclOe),
    .fallStrobe    (fallStrobe),
    .riseStrobe    (riseStrobe)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One period after a fresh enable; S = stretch edges held by the slave
  task automatic runCase(input int L, input int H, input bit d, input int S);
    int lExp, hExp, n, g, h, extra, oeBad;
    string lowReq, highReq;
    @(negedge clk);
    enable = 1'b0;
    holdLow = 1'b0;
    lowCountBase = L[7:0];
    highCountBase = H[7:0];
    countExt = {L[8], H[8]};
    divBy2 = d;
    @(negedge clk);
    enable = 1'b1;
    lExp = ((L == 0) ? 1 : L) * (d ? 2 : 1);
    hExp = ((H == 0) ? 1 : H) * (d ? 2 : 1);
    lowReq  = (L > 255) ? "R9 low" : ((L == 0) ? "R6 low" : (d ? "R5 low" : "R2 low"));
    highReq = (H > 255) ? "R9 high" : ((H == 0) ? "R6 high" : (d ? "R5 high" : "R3 high"));
    do @(negedge clk); while (!fallStrobe);
    n = 0; extra = 0;
    while (sclOe) begin
      n++;
      if (n > 1 && fallStrobe) extra++;
      @(negedge clk);
    end
    check(n == lExp, lowReq, n, lExp);
    g = 0; oeBad = 0;
    while (!riseStrobe) begin
      g++;
      holdLow = (g <= S);
      if (sclOe) oeBad++;
      @(negedge clk);
    end
    holdLow = 1'b0;
    check(g == S + SYNC + 1, "R4 release-to-rise", g, S + SYNC + 1);
    h = 0;
    while (!fallStrobe) begin
      h++;
      if (sclOe) oeBad++;
      if (h > 1 && riseStrobe) extra++;
      @(negedge clk);
    end
    check(h == hExp, highReq, h, hExp);
    check(extra == 0 && oeBad == 0, "R7 strobe shape", extra + oeBad, 0);
    enable = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int act;
    repeat (3) @(negedge clk);
    check(!sclOe && !fallStrobe && !riseStrobe, "R1 reset", {sclOe, fallStrobe, riseStrobe}, 0);
    rstN = 1'b1;
    act = 0;
    repeat (6) begin
      @(negedge clk);
      act += int'(sclOe) + int'(fallStrobe) + int'(riseStrobe);
    end
    check(act == 0, "R1 disabled idle", act, 0);

    // Near-exhaustive sweep of small counts under both divide ratios
    for (int d = 0; d < 2; d++)
      for (int L = 0; L <= 12; L++)
        for (int H = 0; H <= 12; H++)
          runCase(L, H, d[0], 0);

    // Ninth-bit boundaries (R9)
    runCase(511, 256, 1'b1, 0);
    runCase(256, 511, 1'b0, 0);
    runCase(300, 5, 1'b0, 0);
    runCase(255, 257, 1'b0, 0);

    // Slave stretching (R4)
    runCase(3, 4, 1'b0, 1);
    runCase(3, 4, 1'b1, 5);
    runCase(1, 1, 1'b0, 17);
    runCase(20, 2, 1'b1, 9);

    // Disable mid low phase (R8)
    @(negedge clk);
    lowCountBase = 8'd40; highCountBase = 8'd3; countExt = 2'b00; divBy2 = 1'b0;
    enable = 1'b1;
    do @(negedge clk); while (!fallStrobe);
    repeat (10) @(negedge clk);
    check(sclOe, "R8 driving before disable", sclOe, 1);
    enable = 1'b0;
    @(negedge clk);
    check(!sclOe, "R8 release after disable", sclOe, 0);
    act = 0;
    repeat (3) begin
      @(negedge clk);
      act += int'(sclOe) + int'(fallStrobe) + int'(riseStrobe);
    end
    check(act == 0, "R8 quiet while disabled", act, 0);
    runCase(40, 3, 1'b0, 0);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule